// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the timing pulses a UART needs from the system clock. It produces a sample tick at sixteen times the bit rate, for the receiver's oversampling, and a bit tick once per bit time. The bit time is set by an integer divisor D and a 4-bit extension E. Each unit of E adds one extra clock to the bit. The baud rate can therefore be set to single-clock resolution instead of sixteen-clock resolution.

Software writes the divisor through two register strobes. The high register holds the upper bits of D and is only staged. The low register holds D[7:0] in bits 7:0 and E in bits 15:12. Writing the low register commits the staged high bits together with the low fields as one new divisor and restarts both tick sequences. The low register is always written last, so the two halves of the divisor are never mixed. Both outputs are plain one-clock pulses with no handshake. A downstream transmitter or receiver simply acts on the cycles in which they are high.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, both ticks are low. After reset the divisor is D=0, E=0, so the first bit tick comes 16 clocks after the first cycle with `rst_n` high, and further bit ticks come every 16 clocks.
- R2: With a divisor committed, consecutive bit ticks are exactly 16*(D+1)+E clocks apart, for E from 0 to 15.
- R3: Within each bit time there are 16 sample ticks. The first E of them are spaced D+2 clocks apart, counted from the previous sample tick or from the start of the bit. The remaining 16-E are spaced D+1 clocks apart. With D=0 and E=0 the sample tick is high on every clock.
- R4: The bit tick is one clock wide and is high only together with the 16th sample tick of the bit.
- R5: A write to the high divisor register (`div_hi_we`) alone does not change the tick timing. The value is only staged.
- R6: A write to the low divisor register commits D = {staged high bits, `div_lo_wdata[7:0]`} and E = `div_lo_wdata[15:12]`, and restarts the sequence. If the write strobe is high in cycle n, the first bit tick appears in cycle n+16*(D+1)+E. Ticks in cycle n itself still belong to the old divisor.
- R7: Bits 11:8 of `div_lo_wdata` are ignored. Any value there gives the same tick timing as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi_we | input | 1 | Write strobe for the high divisor register |
| div_hi_wdata | input | DIV_W-8 | Upper bits of D (staged) |
| div_lo_we | input | 1 | Write strobe for the low divisor register; commits the divisor |
| div_lo_wdata | input | 16 | D[7:0] in bits 7:0, E in bits 15:12, bits 11:8 ignored |
| sample_tick | output | 1 | One-clock pulse at 16x the bit rate |
| bit_tick | output | 1 | One-clock pulse once per bit time |

## Verification
Both ticks are decoded straight from the counter state, with no output register. A sample tick is due D+1 or D+2 cycles after the previous one, or after the low-register write cycle. A bit tick is due exactly 16*(D+1)+E cycles after the previous bit tick or after that write cycle. The bench drives inputs just after the rising edge and samples at the falling edge against a free-running cycle count. It records the write cycle as the reference, so each measured distance is compared with the exact number from R2, R3 and R6. Ticks seen in the write cycle itself are ignored, because they belong to the old divisor.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int LO_REG_W  = 16;  // width of the low divisor register
  localparam int D_LO_W    = 8;   // divisor bits held in the low register
  localparam int EXT_W     = 4;   // width of the per-bit extension
  localparam int EXT_LSB   = 12;  // position of the extension field
  localparam int SUBTICKS  = 16;  // oversampling ratio
  localparam int SUB_W     = $clog2(SUBTICKS);

  typedef logic [EXT_W-1:0] ext_t;
  typedef logic [SUB_W-1:0] sub_idx_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_we,
  input  logic [DIV_W-9:0]    hi_wdata,
  input  logic                lo_we,
  input  logic [LO_REG_W-1:0] lo_wdata,
  output logic [DIV_W-1:0]    act_d,
  output ext_t                act_e
);
  localparam int HI_W = DIV_W - D_LO_W;

  logic [HI_W-1:0] stage_hi;
  logic [HI_W-1:0] hi_src;

  // A high write in the same cycle as the low write is honoured
  assign hi_src = hi_we ? hi_wdata : stage_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0;
      act_d    <= '0;
      act_e    <= '0;
    end else begin
      if (hi_we) stage_hi <= hi_wdata;
      if (lo_we) begin
        act_d <= {hi_src, lo_wdata[D_LO_W-1:0]};
        act_e <= lo_wdata[EXT_LSB +: EXT_W];
      end
    end
  end

  AST_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we) |=> ($stable(act_d) && $stable(act_e))); // R5

  AST_LO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (act_e == $past(lo_wdata[15:12]) &&
               act_d[D_LO_W-1:0] == $past(lo_wdata[7:0]))); // R7
endmodule

// File: rtl/baud_tick_core.sv
module baud_tick_core
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] act_d,
  input  ext_t             act_e,
  output logic             sample_tick,
  output logic             bit_tick
);
  localparam int CW = DIV_W + 1;
  localparam sub_idx_t LAST_SUB = sub_idx_t'(SUBTICKS - 1);

  logic          live;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  sub_idx_t      idx;
  logic          hit;

  // The first E sub-periods are one clock longer
  assign lim = (idx < act_e) ? (CW'(act_d) + CW'(1)) : CW'(act_d);
  assign hit = live && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else if (restart) begin
      live <= 1'b1;
      cnt  <= '0;
      idx  <= '0;
    end else if (!live) begin
      live <= 1'b1;
    end else if (hit) begin
      cnt  <= '0;
      idx  <= idx + sub_idx_t'(1);
    end else begin
      cnt  <= cnt + CW'(1);
    end
  end

  assign sample_tick = hit;
  assign bit_tick    = hit && (idx == LAST_SUB);

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bit_tick); // R6

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R4

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !restart) |=> (idx == '0)); // R3
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                div_hi_we,
  input  logic [DIV_W-9:0]    div_hi_wdata,
  input  logic                div_lo_we,
  input  logic [LO_REG_W-1:0] div_lo_wdata,
  output logic                sample_tick,
  output logic                bit_tick
);
  logic [DIV_W-1:0] act_d;
  ext_t             act_e;

  baud_div_regs #(.DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_we    (div_hi_we),
    .hi_wdata (div_hi_wdata),
    .lo_we    (div_lo_we),
    .lo_wdata (div_lo_wdata),
    .act_d    (act_d),
    .act_e    (act_e)
  );

  baud_tick_core #(.DIV_W(DIV_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (div_lo_we),
    .act_d       (act_d),
    .act_e       (act_e),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  // Independent period watch: cycles since the last bit tick or load
  localparam int PW = DIV_W + 6;
  logic [PW-1:0] per_cnt;
  logic [PW-1:0] per_total;

  assign per_total = ((PW'(act_d) + PW'(1)) << SUB_W) + PW'(act_e);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       per_cnt <= '0;
    else if (div_lo_we || bit_tick || per_cnt == '0) per_cnt <= PW'(1);
    else                                              per_cnt <= per_cnt + PW'(1);
  end

  AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (per_cnt == per_total)); // R2
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  localparam int DIV_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              div_hi_we = 1'b0;
  logic [DIV_W-9:0]  div_hi_wdata = '0;
  logic              div_lo_we = 1'b0;
  logic [15:0]       div_lo_wdata = '0;
  logic              sample_tick;
  logic              bit_tick;

  always #2.5 clk = ~clk;

  frac_baud_gen #(.DIV_W(DIV_W)) u_frac_baud_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_hi_we    (div_hi_we),
    .div_hi_wdata (div_hi_wdata),
    .div_lo_we    (div_lo_we),
    .div_lo_wdata (div_lo_wdata),
    .sample_tick  (sample_tick),
    .bit_tick     (bit_tick)
  );

  int compared = 0;
  int mismatched = 0;
  int exp_q[$];
  int cyc = 0;
  int ref_cyc = 0, last_samp = 0, samp_idx = 0;
  int cur_d = 0, cur_e = 0, pend_d = 0, pend_e = 0, model_hi = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  function automatic int period(int d, int e);
    return 16 * (d + 1) + e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: samples away from the active edge and compares
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      armed = 1'b0;
      cur_d = 0; cur_e = 0;
      if (cyc % 2 == 0)
        check(!sample_tick && !bit_tick, "R1 reset quiet",
              int'(sample_tick) + int'(bit_tick), 0);
    end else if (!armed || div_lo_we) begin
      armed = 1'b1;
      ref_cyc = cyc; last_samp = cyc; samp_idx = 0;
      if (div_lo_we) begin cur_d = pend_d; cur_e = pend_e; end
    end else begin
      if (sample_tick) begin
        int exp_sp;
        exp_sp = (samp_idx < cur_e) ? cur_d + 2 : cur_d + 1;
        check(cyc - last_samp == exp_sp, "R3 sample spacing", cyc - last_samp, exp_sp);
        last_samp = cyc;
        samp_idx++;
        if (bit_tick) begin
          check(samp_idx == 16, "R4 bit on 16th sample", samp_idx, 16);
          samp_idx = 0;
        end
      end else if (bit_tick) begin
        check(1'b0, "R4 bit tick without sample tick", 0, 1);
      end
      if (bit_tick) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(cyc - ref_cyc == e, "R2/R6 bit interval", cyc - ref_cyc, e);
        end
        ref_cyc = cyc;
      end
    end
  end

  // Driver tasks
  task automatic wr_hi(int v);
    @(posedge clk); #1;
    div_hi_we = 1'b1; div_hi_wdata = (DIV_W-8)'(v);
    model_hi = v;
    @(posedge clk); #1;
    div_hi_we = 1'b0;
  endtask

  task automatic wr_lo(int lo, int e, int junk);
    @(posedge clk); #1;
    pend_d = model_hi * 256 + lo;
    pend_e = e;
    div_lo_we = 1'b1;
    div_lo_wdata = {4'(e), 4'(junk), 8'(lo)};
    @(posedge clk); #1;
    div_lo_we = 1'b0;
  endtask

  task automatic expect_bits(int n, int per);
    for (int i = 0; i < n; i++) exp_q.push_back(per);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", exp_q.size(), 0);
      summary();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    exp_q.push_back(period(0, 0));            // R1 first tick after reset
    rst_n = 1'b1;
    expect_bits(2, period(0, 0));             // R1 default period
    wr_lo(0, 15, 0);                          // R2 fastest with full extension
    expect_bits(3, period(0, 15));
    wr_lo(3, 5, 0);                           // R2, R3 mixed spacing
    expect_bits(3, period(3, 5));
    wr_hi(1);                                 // R5 staged only
    expect_bits(3, period(3, 5));
    wr_lo(5, 3, 0);                           // R6 commit D = 0x105
    expect_bits(2, period(261, 3));
    wr_hi(0);
    wr_lo(10, 0, 15);                         // R7 bits 11:8 ignored
    expect_bits(3, period(10, 0));
    wr_lo(2, 9, 10);                          // R7 other junk, R6 restart
    expect_bits(3, period(2, 9));
    wr_lo(0, 0, 0);                           // R3 tick every clock
    expect_bits(3, period(0, 0));
    done = 1'b1;
    repeat (3) @(posedge clk);
    summary();
  end
endmodule